// File: doc/BRIEF.md
# Register-Target Conditional Branch Unit

This unit decides whether a branch instruction of a 32-bit load-store processor redirects control, and it keeps the program counter that the decision updates. It receives a decoded opcode, a 3-bit condition selector, the value of the register that holds the jump target, and the value of the register being tested. The unit holds the current PC in a register. That PC has already been advanced past the instruction being evaluated.

On each valid instruction the unit picks the address of the next instruction. That address is the register target when the branch is taken, and the sequential address otherwise. The PC register then becomes that address plus 4. The branch-and-link opcode always asks for a write of the advanced PC into the link register, whether or not the branch is taken. The link value is taken from the PC before the clock edge that redirects it. The register file, the fetch path and any pipelining sit outside the unit.

Top module: `branch_unit`

## Requirements
- R1: While rst_ni is low, pc_o equals RESET_PC (default 0x0000_0004), and taken_o and link_we_o are 0 whenever valid_i is 0.
- R2: Condition codes 000, 110 and 111 on cond_i never take the branch.
- R3: Condition code 001 always takes the branch.
- R4: Code 010 takes the branch when test_i is zero, and code 011 takes it when test_i is nonzero.
- R5: Code 100 takes the branch when bit 31 of test_i is 0, and code 101 takes it when bit 31 is 1.
- R6: A taken branch sets next_pc_o to the full 32-bit target_i, with no offset added. After the edge, pc_o holds target_i + 4.
- R7: Opcode 8 (op_i = 5'd8) is the plain conditional branch, and it never asserts link_we_o.
- R8: Opcode 9 (op_i = 5'd9) is branch-and-link. With valid_i high it asserts link_we_o, and link_data_o carries the current advanced pc_o, whether or not the branch is taken.
- R9: A valid instruction that does not take the branch, including any opcode other than 8 and 9, sets next_pc_o to pc_o. After the edge, pc_o holds that value + 4.
- R10: With valid_i low, pc_o holds its value, and taken_o and link_we_o are 0.
- R11: When branch-and-link is taken, link_data_o in that cycle is the PC from before the redirect, not the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 5 | Opcode (8 branch, 9 branch-and-link) |
| cond_i | input | 3 | Condition selector |
| target_i | input | 32 | Value of the target register |
| test_i | input | 32 | Value of the tested register |
| pc_o | output | 32 | Registered PC, already advanced past the current instruction |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | The branch is taken |
| link_we_o | output | 1 | Link register write enable |
| link_data_o | output | 32 | Value to write to the link register |

## Verification
In one cycle, a taken branch-and-link both writes the link register and redirects the PC. The bench provokes this by issuing opcode 9 with codes that are always taken, and with zero and sign codes whose test register satisfies the condition. It then judges two things. The link value sampled before the edge must equal the advanced PC from before the redirect. The PC seen one cycle later must equal the target plus 4. The scoreboard predicts both values from its own PC model.

// File: rtl/bu_pkg.sv
package bu_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned OP_W = 5;
  localparam int unsigned CC_W = 3;

  localparam logic [OP_W-1:0] OP_BR  = 5'd8;
  localparam logic [OP_W-1:0] OP_BRL = 5'd9;

  localparam logic [CC_W-1:0] CC_NEVER   = 3'd0;
  localparam logic [CC_W-1:0] CC_ALWAYS  = 3'd1;
  localparam logic [CC_W-1:0] CC_ZERO    = 3'd2;
  localparam logic [CC_W-1:0] CC_NONZERO = 3'd3;
  localparam logic [CC_W-1:0] CC_PLUS    = 3'd4;
  localparam logic [CC_W-1:0] CC_MINUS   = 3'd5;

  typedef enum logic [1:0] {
    K_OTHER = 2'd0,
    K_BR    = 2'd1,
    K_BRL   = 2'd2
  } br_kind_e;

  function automatic br_kind_e kind_of(input logic [OP_W-1:0] op);
    case (op)
      OP_BR:   return K_BR;
      OP_BRL:  return K_BRL;
      default: return K_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/bu_cond_eval.sv
module bu_cond_eval
  import bu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [CC_W-1:0] cond_i,
  input  logic [W-1:0]    test_i,
  output logic            hit_o
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (test_i == '0);
  assign is_neg  = test_i[W-1];

  always_comb begin
    case (cond_i)
      CC_ALWAYS:  hit_o = 1'b1;
      CC_ZERO:    hit_o = is_zero;
      CC_NONZERO: hit_o = !is_zero;
      CC_PLUS:    hit_o = !is_neg;
      CC_MINUS:   hit_o = is_neg;
      default:    hit_o = 1'b0; // 000, 110, 111
    endcase
  end
endmodule

// File: rtl/bu_pc_reg.sv
module bu_pc_reg
  import bu_pkg::*;
#(
  parameter int unsigned      W        = XLEN,
  parameter int unsigned      STEP     = 4,
  parameter logic [XLEN-1:0]  RESET_PC = 32'h0000_0004
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         redirect_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] pc_o
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= RESET_PC[W-1:0];
    else if (adv_i) pc_q <= next_i + STEP_V;
  end

  assign pc_o = pc_q;

  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pc_o));

  // R9
  seq_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !redirect_i |=> pc_o == $past(pc_o) + STEP_V);
endmodule

// File: rtl/bu_next_sel.sv
module bu_next_sel
  import bu_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         valid_i,
  input  br_kind_e     kind_i,
  input  logic         hit_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] target_i,
  output logic         taken_o,
  output logic         link_we_o,
  output logic [W-1:0] next_o
);
  logic is_branch;

  assign is_branch = (kind_i == K_BR) || (kind_i == K_BRL);
  assign taken_o   = valid_i && is_branch && hit_i;
  assign link_we_o = valid_i && (kind_i == K_BRL);
  assign next_o    = taken_o ? target_i : pc_i;
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import bu_pkg::*;
#(
  parameter int unsigned     W        = XLEN,
  parameter int unsigned     STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0004
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [CC_W-1:0] cond_i,
  input  logic [W-1:0]    target_i,
  input  logic [W-1:0]    test_i,
  output logic [W-1:0]    pc_o,
  output logic [W-1:0]    next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [W-1:0]    link_data_o
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  br_kind_e     kind;
  logic         hit;
  logic [W-1:0] pc_cur;

  assign kind = kind_of(op_i);

  bu_cond_eval #(.W(W)) u_cond (
    .cond_i (cond_i),
    .test_i (test_i),
    .hit_o  (hit)
  );

  bu_next_sel #(.W(W)) u_sel (
    .valid_i   (valid_i),
    .kind_i    (kind),
    .hit_i     (hit),
    .pc_i      (pc_cur),
    .target_i  (target_i),
    .taken_o   (taken_o),
    .link_we_o (link_we_o),
    .next_o    (next_pc_o)
  );

  bu_pc_reg #(.W(W), .STEP(STEP), .RESET_PC(RESET_PC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (valid_i),
    .redirect_i (taken_o),
    .next_i     (next_pc_o),
    .pc_o       (pc_cur)
  );

  // link value is the pre-update advanced PC
  assign link_data_o = pc_cur;
  assign pc_o        = pc_cur;

  // R6
  taken_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && taken_o |=> pc_o == $past(target_i) + STEP_V);

  // R2
  never_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (cond_i == CC_NEVER || cond_i[2:1] == 2'b11) |-> !taken_o);

  // R7
  br_no_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_BR |-> !link_we_o);

  // R11
  link_before_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o && taken_o |=> $past(link_data_o) + STEP_V != pc_o || $past(target_i) == $past(link_data_o));

  // R3
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_BRL && cond_i == CC_ALWAYS |-> taken_o && link_we_o);
endmodule

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
  localparam logic [31:0] RST_PC = 32'h0000_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic [2:0]  cc = '0;
  logic [31:0] tgt = '0;
  logic [31:0] tst = '0;
  logic [31:0] pc, nxt, link;
  logic        taken, lwe;

  int checks = 0;
  int errors = 0;
  logic [31:0] mpc = RST_PC;
  bit drv_done = 1'b0;

  typedef struct {
    string       req;
    logic [31:0] pc;
    logic [31:0] nxt;
    logic        taken;
    logic        lwe;
    logic [31:0] link;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  branch_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .cond_i(cc),
    .target_i(tgt), .test_i(tst), .pc_o(pc), .next_pc_o(nxt),
    .taken_o(taken), .link_we_o(lwe), .link_data_o(link)
  );

  function automatic logic model_hit(input logic [2:0] c, input logic [31:0] t);
    case (c)
      3'd1: return 1'b1;
      3'd2: return t == 0;
      3'd3: return t != 0;
      3'd4: return !t[31];
      3'd5: return t[31];
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input string req, input logic v, input logic [4:0] o,
                       input logic [2:0] c, input logic [31:0] t, input logic [31:0] s);
    item_t it;
    logic tk;
    @(posedge clk);
    #5;
    valid = v; op = o; cc = c; tgt = t; tst = s;
    tk = v && (o == 5'd8 || o == 5'd9) && model_hit(c, s);
    it.req = req; it.pc = mpc; it.taken = tk;
    it.nxt = tk ? t : mpc;
    it.lwe = v && (o == 5'd9);
    it.link = mpc;
    q.push_back(it);
    if (v) mpc = it.nxt + 32'd4;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (pc !== e.pc || taken !== e.taken || lwe !== e.lwe ||
            (e.lwe && link !== e.link) || nxt !== e.nxt) begin
          errors++;
          $display("FAIL %s: pc=%h nxt=%h tk=%b lwe=%b link=%h exp pc=%h nxt=%h tk=%b lwe=%b link=%h",
                   e.req, pc, nxt, taken, lwe, link, e.pc, e.nxt, e.taken, e.lwe, e.link);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: run hung, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    #25;
    checks++;
    if (pc !== RST_PC || lwe !== 1'b0 || taken !== 1'b0) begin
      errors++;
      $display("FAIL R1: pc=%h lwe=%b tk=%b exp pc=%h lwe=0 tk=0", pc, lwe, taken, RST_PC);
    end
    @(negedge clk); rst_n = 1'b1;
    // R9 non-branch opcode advances sequentially
    drive("R9", 1, 5'd12, 3'd1, 32'h0000_0400, 32'h0);
    // R2 never codes, with both opcodes
    drive("R2", 1, 5'd8, 3'd0, 32'h0000_0800, 32'h0);
    drive("R2", 1, 5'd9, 3'd6, 32'h0000_0800, 32'h0);
    drive("R2", 1, 5'd8, 3'd7, 32'h0000_0800, 32'hFFFF_FFFF);
    // R3 always, R7 no link on plain branch, R6 full target
    drive("R3_R7_R6", 1, 5'd8, 3'd1, 32'hDEAD_BEE0, 32'h5);
    // R4 zero / nonzero
    drive("R4", 1, 5'd8, 3'd2, 32'h0000_1000, 32'h0);
    drive("R4", 1, 5'd8, 3'd2, 32'h0000_2000, 32'h1);
    drive("R4", 1, 5'd8, 3'd3, 32'h0000_3000, 32'h8000_0000);
    drive("R4", 1, 5'd8, 3'd3, 32'h0000_4000, 32'h0);
    // R5 sign tests
    drive("R5", 1, 5'd8, 3'd4, 32'h0000_5000, 32'h7FFF_FFFF);
    drive("R5", 1, 5'd8, 3'd4, 32'h0000_6000, 32'h8000_0000);
    drive("R5", 1, 5'd8, 3'd5, 32'h0000_7000, 32'hC000_0001);
    drive("R5", 1, 5'd8, 3'd5, 32'h0000_8000, 32'h0000_0001);
    // R8 link on not-taken branch-and-link
    drive("R8", 1, 5'd9, 3'd0, 32'h0000_9000, 32'h0);
    drive("R8", 1, 5'd9, 3'd2, 32'h0000_9000, 32'h3);
    // R11 taken branch-and-link: link and redirect in the same cycle
    drive("R11", 1, 5'd9, 3'd1, 32'h0001_0000, 32'h0);
    drive("R11", 1, 5'd9, 3'd3, 32'h0002_0000, 32'h9);
    drive("R11", 1, 5'd9, 3'd5, 32'hFFFF_FFF0, 32'h8000_0000);
    // R10 idle holds pc, even with branch-and-link opcode present
    drive("R10", 0, 5'd9, 3'd1, 32'h0003_0000, 32'h0);
    drive("R10", 0, 5'd8, 3'd1, 32'h0004_0000, 32'h0);
    // R9 non-branch opcode after idle
    drive("R9", 1, 5'd0, 3'd1, 32'h0005_0000, 32'h0);
    drive("R6", 0, 5'd0, 3'd0, 32'h0, 32'h0);
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    drv_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule